// File: doc/BRIEF.md
# Oversampling Parallel-to-Serial Transmit Shifter

This block turns parallel transmit words into a serial bit stream. Each word is either 16 or 20 bits wide, and the width is chosen at runtime. Bits leave least significant first, and each one is held on the serial output for one bit period. The bit period comes from a small rate divider that runs off the fast clock. The divider can be set to 1, 2 or 4, so a new serial bit appears every one, two or four fast-clock cycles. A companion `bit_tick` output marks the cycle in which each new serial bit first appears.

For low line rates, an oversampling mode sends every data bit as five identical serial bits in a row. In this mode a 16-bit word takes 80 bit periods and a 20-bit word takes 100. Low line rates means roughly the 150 to 750 Mb/s band, where the fast clock cannot be slowed enough.

The width select and the oversampling select are captured only when a word is loaded. A change made partway through a word therefore applies to the next word. A one-cycle `word_req` pulse coincides with the final serial bit of each word. The source must present the next word before the following bit period starts, because that word is loaded then. Out of reset the shifter is empty, and it loads whatever `word_in` holds on the first bit period.

Top module: `lane_serializer`

## Requirements
- R1: `wide_sel` = 0 sends 16 data bits per word and `wide_sel` = 1 sends 20. In 16-bit mode, `word_in[19:16]` has no effect on the output.
- R2: Data bits are sent least significant first. Each serial bit holds `ser_out` constant from its `bit_tick` cycle until the next `bit_tick`.
- R3: With `ovs_en` = 1 at load, every data bit of that word appears on five consecutive bit periods. With `ovs_en` = 0 it appears on one.
- R4: `div_sel` sets the bit period: 2'b00 gives 1 clock, 2'b01 gives 2 clocks, and 2'b10 or 2'b11 give 4 clocks between consecutive `bit_tick` pulses.
- R5: `word_req` is high for exactly the one cycle whose `bit_tick` carries the last serial bit of a word, including the last of five repeats. It is low in every other cycle.
- R6: The word on `word_in` at the bit period following a `word_req` is loaded, and its bit 0 appears with that period's `bit_tick`.
- R7: `wide_sel` and `ovs_en` are sampled only when a word is loaded. Changing them during a word does not alter that word's length or repetition.
- R8: While `rst_n` is low, `ser_out`, `bit_tick` and `word_req` are 0. The first `bit_tick` after reset carries bit 0 of `word_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_in | input | WIDE_W (20) | Parallel word to transmit |
| wide_sel | input | 1 | 0: 16-bit word, 1: 20-bit word |
| ovs_en | input | 1 | 1: repeat each bit five times |
| div_sel | input | 2 | Bit-period divider code (1, 2, 4, 4) |
| ser_out | output | 1 | Serial data, LSB first |
| bit_tick | output | 1 | High in the cycle a new serial bit appears |
| word_req | output | 1 | High with the last serial bit of a word |

## Verification
The bench attacks the word boundary. Consecutive words alternate width and oversampling, and the selects are scrambled right after every load. A design that sampled the selects continuously would then send words of the wrong length, and the scoreboard would fall out of step at once. Oversampled words check the repeat count: sending four or six copies of a bit would misplace every later bit and the `word_req` pulse. Each divider code is run from reset with the tick spacing measured, which catches a divider off by one or a wrongly decoded spare code. In narrow mode the top four bits of `word_in` carry junk that must never reach the line.

// File: rtl/ser_pkg.sv
package ser_pkg;

   typedef enum logic [1:0] {
      RATE_FULL  = 2'b00,
      RATE_HALF  = 2'b01,
      RATE_QTR   = 2'b10,
      RATE_QTR_B = 2'b11
   } rate_code_e;

   // terminal count of the divider for a given code (period - 1)
   function automatic logic [1:0] rate_last(input logic [1:0] code);
      case (rate_code_e'(code))
         RATE_FULL: rate_last = 2'd0;
         RATE_HALF: rate_last = 2'd1;
         default:   rate_last = 2'd3;
      endcase
   endfunction

endpackage

// File: rtl/ser_rate_gen.sv
module ser_rate_gen
   import ser_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] div_code,
   output logic       stb
);
   logic [1:0] cnt_q;
   logic [1:0] lim;

   assign lim = rate_last(div_code);
   assign stb = (cnt_q >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt_q <= 2'd0;
      else if (stb) cnt_q <= 2'd0;
      else          cnt_q <= cnt_q + 2'd1;
   end
endmodule

// File: rtl/ser_shift_core.sv
module ser_shift_core #(
   parameter int NARROW_W = 16,
   parameter int WIDE_W   = 20,
   parameter int REPEAT   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic [WIDE_W-1:0] word_in,
   input  logic              wide_sel,
   input  logic              ovs_en,
   output logic              ser_out,
   output logic              bit_tick,
   output logic              word_req
);
   localparam int IDX_W = $clog2(WIDE_W);
   localparam int REP_W = $clog2(REPEAT);
   localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(WIDE_W - 1);
   localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(NARROW_W - 1);
   localparam logic [REP_W-1:0] LAST_REP    = REP_W'(REPEAT - 1);

   logic [WIDE_W-1:0] sh_q,   sh_n;
   logic [IDX_W-1:0]  left_q, left_n;
   logic [REP_W-1:0]  rep_q,  rep_n;
   logic              ovs_q,  ovs_n;
   logic              ser_q,  ser_n;
   logic              at_end, end_n;

   assign at_end = (left_q == '0) && (rep_q == '0);

   always_comb begin
      sh_n   = sh_q;
      left_n = left_q;
      rep_n  = rep_q;
      ovs_n  = ovs_q;
      ser_n  = ser_q;
      if (stb) begin
         if (at_end) begin
            // word boundary: capture data and both selects
            ser_n  = word_in[0];
            sh_n   = word_in >> 1;
            left_n = wide_sel ? LAST_WIDE : LAST_NARROW;
            rep_n  = ovs_en ? LAST_REP : '0;
            ovs_n  = ovs_en;
         end else if (rep_q != '0) begin
            rep_n = rep_q - 1'b1;
         end else begin
            ser_n  = sh_q[0];
            sh_n   = sh_q >> 1;
            left_n = left_q - 1'b1;
            rep_n  = ovs_q ? LAST_REP : '0;
         end
      end
   end

   assign end_n = (left_n == '0) && (rep_n == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q     <= '0;
         left_q   <= '0;
         rep_q    <= '0;
         ovs_q    <= 1'b0;
         ser_q    <= 1'b0;
         bit_tick <= 1'b0;
         word_req <= 1'b0;
      end else begin
         sh_q     <= sh_n;
         left_q   <= left_n;
         rep_q    <= rep_n;
         ovs_q    <= ovs_n;
         ser_q    <= ser_n;
         bit_tick <= stb;
         word_req <= stb && end_n;
      end
   end

   assign ser_out = ser_q;
endmodule

// File: rtl/lane_serializer.sv
module lane_serializer #(
   parameter int NARROW_W = 16,
   parameter int WIDE_W   = 20,
   parameter int REPEAT   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDE_W-1:0] word_in,
   input  logic              wide_sel,
   input  logic              ovs_en,
   input  logic [1:0]        div_sel,
   output logic              ser_out,
   output logic              bit_tick,
   output logic              word_req
);
   logic stb;

   generate
      if (NARROW_W < 2 || NARROW_W >= WIDE_W) begin : g_bad_width
         $error("lane_serializer: need 2 <= NARROW_W < WIDE_W");
      end
      if (REPEAT < 2) begin : g_bad_repeat
         $error("lane_serializer: REPEAT must be at least 2");
      end
   endgenerate

   ser_rate_gen u_rate (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_code (div_sel),
      .stb      (stb)
   );

   ser_shift_core #(
      .NARROW_W (NARROW_W),
      .WIDE_W   (WIDE_W),
      .REPEAT   (REPEAT)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (stb),
      .word_in  (word_in),
      .wide_sel (wide_sel),
      .ovs_en   (ovs_en),
      .ser_out  (ser_out),
      .bit_tick (bit_tick),
      .word_req (word_req)
   );
endmodule

// File: rtl/ser_props.sv
module ser_props #(
   parameter int NARROW_W = 16,
   parameter int WIDE_W   = 20,
   parameter int REPEAT   = 5
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] div_sel,
   input logic       ser_out,
   input logic       bit_tick,
   input logic       word_req
);
   localparam int CNT_W = $clog2(WIDE_W * REPEAT + 1);

   logic [CNT_W-1:0] ticks_q;
   logic [CNT_W-1:0] ticks_now;
   assign ticks_now = ticks_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n)        ticks_q <= '0;
      else if (word_req) ticks_q <= '0;
      else if (bit_tick) ticks_q <= ticks_now;
   end

   assert_req_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      word_req |-> bit_tick);

   assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      word_req |=> !word_req);

   assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |-> $stable(ser_out));

   assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick && div_sel != 2'b00) |=> !bit_tick);

   assert_word_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      word_req |-> (ticks_now == CNT_W'(NARROW_W) || ticks_now == CNT_W'(WIDE_W) ||
                    ticks_now == CNT_W'(NARROW_W * REPEAT) ||
                    ticks_now == CNT_W'(WIDE_W * REPEAT)));
endmodule

bind lane_serializer ser_props #(
   .NARROW_W (NARROW_W),
   .WIDE_W   (WIDE_W),
   .REPEAT   (REPEAT)
) u_props (
   .clk      (clk),
   .rst_n    (rst_n),
   .div_sel  (div_sel),
   .ser_out  (ser_out),
   .bit_tick (bit_tick),
   .word_req (word_req)
);

// File: tb/sim_lane_serializer.sv
module sim_lane_serializer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] word_in = '0;
   logic        wide_sel = 1'b0;
   logic        ovs_en = 1'b0;
   logic [1:0]  div_sel = 2'b00;
   logic        ser_out, bit_tick, word_req;

   int tests = 0;
   int fails = 0;
   bit drv_done = 1'b1;
   int gap_cnt = 0;
   bit seen_tick = 1'b0;
   logic [2:0] exp_q[$];   // {first, last, bit}

   always #2 clk = ~clk;   // 250 MHz

   lane_serializer u0 (
      .clk(clk), .rst_n(rst_n), .word_in(word_in), .wide_sel(wide_sel),
      .ovs_en(ovs_en), .div_sel(div_sel), .ser_out(ser_out),
      .bit_tick(bit_tick), .word_req(word_req)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic push_word(input logic [19:0] w, input logic wd, input logic ov);
      int n = wd ? 20 : 16;
      int r = ov ? 5 : 1;
      for (int i = 0; i < n; i++)
         for (int k = 0; k < r; k++)
            exp_q.push_back({(i == 0 && k == 0), (i == n-1 && k == r-1), w[i]});
   endtask

   function automatic int period_of(input logic [1:0] c);
      return (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : 4;
   endfunction

   // monitor: pops the scoreboard on every bit tick
   always @(negedge clk) begin
      logic [2:0] e;
      if (!rst_n) begin
         gap_cnt = 0;
         seen_tick = 1'b0;
      end else begin
         gap_cnt++;
         if (bit_tick) begin
            if (seen_tick)
               chk(gap_cnt == period_of(div_sel), "R4 tick spacing", gap_cnt, period_of(div_sel));
            gap_cnt = 0;
            seen_tick = 1'b1;
            if (exp_q.size() > 0) begin
               e = exp_q.pop_front();
               if (e[2])
                  chk(ser_out == e[0], "R6 R8 first bit of loaded word", ser_out, e[0]);
               else
                  chk(ser_out == e[0], "R1 R2 R3 R7 serial bit", ser_out, e[0]);
               chk(word_req == e[1], "R5 request on last bit", word_req, e[1]);
            end else if (!drv_done) begin
               chk(1'b0, "R6 tick with no expected bit", 1, 0);
            end
         end else begin
            chk(word_req == 1'b0, "R5 request without tick", word_req, 0);
         end
      end
   end

   task automatic wait_tick();
      do @(negedge clk); while (!bit_tick);
   endtask

   task automatic scramble(input int i);
      word_in  = 20'hFFFFF ^ 20'(i * 20'h3B1);
      wide_sel = ~wide_sel;
      ovs_en   = ~ovs_en;
   endtask

   task automatic run_phase(input logic [1:0] code, input int nwords, input int ph);
      logic [19:0] w;
      logic [1:0]  m;
      @(negedge clk);
      rst_n = 1'b0;
      drv_done = 1'b0;
      div_sel = code;
      m = 2'(ph);
      w = 20'hF0000 | 20'(32'h5A3C ^ (ph * 32'h1357));
      word_in = w; wide_sel = m[0]; ovs_en = m[1];
      push_word(w, m[0], m[1]);
      repeat (3) @(negedge clk);
      chk(ser_out == 1'b0 && bit_tick == 1'b0 && word_req == 1'b0, "R8 reset outputs",
          {ser_out, bit_tick, word_req}, 0);
      rst_n = 1'b1;
      wait_tick();
      scramble(ph);
      for (int i = 1; i < nwords; i++) begin
         do @(negedge clk); while (!word_req);
         m = 2'(i + ph);
         w = 20'(32'hA5C3E ^ (i * 32'h1F1F1) ^ (ph * 32'h7777));
         word_in = w; wide_sel = m[0]; ovs_en = m[1];
         push_word(w, m[0], m[1]);
         wait_tick();
         scramble(i);
      end
      while (exp_q.size() > 0) @(negedge clk);
      drv_done = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      run_phase(2'b00, 8, 0);
      run_phase(2'b01, 6, 1);
      run_phase(2'b10, 5, 2);
      run_phase(2'b11, 4, 3);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule